// File: doc/BRIEF.md
# PS/2 Keyboard Host Port

This block is the host side of a PS/2 keyboard link, with a two-location, byte-wide register window for a processor. The keyboard drives the clock and sends 11-bit frames, which the block synchronises, shifts in on falling clock edges and checks for odd parity and a high stop bit before it loads the byte into a data register and raises a full flag. Software either polls the status register or enables an interrupt.

Commands written to the data register go out to the keyboard. The block holds the clock low for a programmable inhibit time, then drives a start bit and releases the clock. It presents each bit while the keyboard holds the clock low, adds the parity bit itself and then samples the keyboard's acknowledge. Only one command can be in flight at a time. A write that arrives while a command is pending is refused and flagged. A completed send feeds the same interrupt line as a received byte. A stalled clock in the middle of a frame returns the port to idle.

Top module: `kbd_host_port`

## Requirements
- R1: After reset both line drivers are off (ps2_clk_oe and ps2_dat_oe low), the status byte reads 0x00 and irq is low.
- R2: A frame is a 0 start bit, 8 data bits LSB first, an odd parity bit and a 1 stop bit, each sampled on a falling clock edge. A valid frame loads its byte into the data register (cpu_addr=0) and sets status bit 0 (full).
- R3: A frame with wrong parity or a 0 stop bit sets status bit 2 (receive error) and leaves both the data register and the full flag unchanged.
- R4: Control bit 0 (written at cpu_addr=1) enables the interrupt. irq is high exactly when that enable is set and either full (status bit 0) or send-done (status bit 4) is set. Status bit 6 reads back the enable.
- R5: A data-register write starts a send. The clock is driven low for INHIBIT_CYC cycles, then data is driven low and the clock is released in the same cycle. After falling edges 1 to 9 the line carries data bits LSB first, then odd parity. After the 10th falling edge data is released (stop bit).
- R6: Status bit 1 shows a send in progress. A data-register write during a send sets status bit 3 (busy) and has no effect on the byte being sent.
- R7: The acknowledge is sampled on the 11th falling edge. A 0 sets status bit 4 (send done), and a 1 sets status bit 5 (no acknowledge).
- R8: Reading the data register clears full and drops irq. Reading the status register clears bits 2, 3, 4 and 5.
- R9: If the clock stays high for TIMEOUT_CYC cycles in the middle of a received frame, the partial frame is dropped, and the next whole frame is received without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_sel | input | 1 | Register access strobe, one cycle per access |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 1 | 0 = data register, 1 = status (read) / control (write) |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Shared interrupt for receive and send completion |
| ps2_clk_i | input | 1 | Sensed level of the keyboard clock line |
| ps2_dat_i | input | 1 | Sensed level of the keyboard data line |
| ps2_clk_oe | output | 1 | 1 pulls the clock line low |
| ps2_dat_oe | output | 1 | 1 pulls the data line low |

## Verification
The hardest situations to reach are a refused command write and a mid-frame stall, because both need the keyboard side to be in a particular phase when the processor acts. The bench models the keyboard as an open-drain partner that can answer a send bit by bit. It issues the second write while the clock is still inhibited, then captures every bit the host presents so it can show that the first byte went out unchanged. For the stall, the keyboard model stops clocking after four bits and waits past the timeout before it sends a clean frame.

// File: rtl/kbd_host_port.sv
module kbd_host_port #(
  parameter int INHIBIT_CYC = 5000,
  parameter int TIMEOUT_CYC = 100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_sel,
  input  logic       cpu_we,
  input  logic       cpu_addr,
  input  logic [7:0] cpu_wdata,
  output logic [7:0] cpu_rdata,
  output logic       irq,
  input  logic       ps2_clk_i,
  input  logic       ps2_dat_i,
  output logic       ps2_clk_oe,
  output logic       ps2_dat_oe
);
  localparam int TMAX = (INHIBIT_CYC > TIMEOUT_CYC) ? INHIBIT_CYC : TIMEOUT_CYC;
  localparam int TW   = $clog2(TMAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_RX, S_INH, S_TX} state_t;

  state_t      state;
  logic [1:0]  csync, dsync;
  logic        clk_d;
  logic [3:0]  cnt;
  logic [7:0]  sr, dout;
  logic        rpar;
  logic [9:0]  txbits;
  logic [TW-1:0] tmr;
  logic        obf, err_q, busy_q, done_q, nack_q, ie_q;

  wire clk_s   = csync[1];
  wire dat_s   = dsync[1];
  wire fall    = clk_d & ~clk_s;
  wire wr_data = cpu_sel & cpu_we & ~cpu_addr;
  wire wr_ctl  = cpu_sel & cpu_we &  cpu_addr;
  wire rd_data = cpu_sel & ~cpu_we & ~cpu_addr;
  wire rd_stat = cpu_sel & ~cpu_we &  cpu_addr;
  wire pending = (state == S_INH) || (state == S_TX);
  wire rx_last = (state == S_RX) && fall && (cnt == 4'd9);
  wire rx_ok   = dat_s && (^{sr, rpar});
  wire rx_store = rx_last && rx_ok;
  wire rx_bad   = rx_last && !rx_ok;
  wire timed_out = (tmr == TW'(TIMEOUT_CYC - 1));

  wire [7:0] status = {1'b0, ie_q, nack_q, done_q, busy_q, err_q, pending, obf};

  assign cpu_rdata = cpu_addr ? status : dout;
  assign irq       = ie_q & (obf | done_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csync <= 2'b11;
      dsync <= 2'b11;
      clk_d <= 1'b1;
    end else begin
      csync <= {csync[0], ps2_clk_i};
      dsync <= {dsync[0], ps2_dat_i};
      clk_d <= clk_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      sr         <= '0;
      rpar       <= 1'b0;
      txbits     <= '0;
      tmr        <= '0;
      dout       <= '0;
      obf        <= 1'b0;
      err_q      <= 1'b0;
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      nack_q     <= 1'b0;
      ie_q       <= 1'b0;
      ps2_clk_oe <= 1'b0;
      ps2_dat_oe <= 1'b0;
    end else begin
      if (rd_stat) begin
        err_q  <= 1'b0;
        busy_q <= 1'b0;
        done_q <= 1'b0;
        nack_q <= 1'b0;
      end
      if (rd_data) obf <= 1'b0;
      if (wr_ctl)  ie_q <= cpu_wdata[0];
      tmr <= tmr + 1'b1;

      case (state)
        S_IDLE: begin
          tmr <= '0;
          if (fall && !dat_s) begin
            state <= S_RX;
            cnt   <= '0;
          end
        end
        S_RX: begin
          if (fall) begin
            tmr <= '0;
            cnt <= cnt + 1'b1;
            if (cnt < 4'd8) sr <= {dat_s, sr[7:1]};
            if (cnt == 4'd8) rpar <= dat_s;
            if (cnt == 4'd9) state <= S_IDLE;
          end else if (timed_out) begin
            state <= S_IDLE;
          end
        end
        S_INH: begin
          if (tmr == TW'(INHIBIT_CYC - 1)) begin
            ps2_clk_oe <= 1'b0;
            ps2_dat_oe <= 1'b1;
            state      <= S_TX;
            cnt        <= '0;
            tmr        <= '0;
          end
        end
        S_TX: begin
          if (fall) begin
            tmr <= '0;
            cnt <= cnt + 1'b1;
            if (cnt < 4'd10) ps2_dat_oe <= ~txbits[cnt];
            if (cnt == 4'd10) begin
              state <= S_IDLE;
              if (!dat_s) done_q <= 1'b1;
              else        nack_q <= 1'b1;
            end
          end else if (timed_out) begin
            state      <= S_IDLE;
            ps2_dat_oe <= 1'b0;
            nack_q     <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase

      if (wr_data) begin
        if (pending) begin
          busy_q <= 1'b1;
        end else begin
          txbits     <= {1'b1, ~^cpu_wdata, cpu_wdata};
          state      <= S_INH;
          tmr        <= '0;
          ps2_clk_oe <= 1'b1;
          ps2_dat_oe <= 1'b0;
        end
      end

      if (rx_store) begin
        dout <= sr;
        obf  <= 1'b1;
      end
      if (rx_bad) err_q <= 1'b1;
    end
  end

  assert_read_clears_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !rx_store) |=> !obf);

  assert_refused_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && pending) |=> (busy_q && $stable(txbits)));

  assert_err_keeps_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $stable(dout));

  assert_start_at_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ps2_clk_oe) |-> ps2_dat_oe);

  assert_lines_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ps2_clk_oe && ps2_dat_oe));

  assert_done_from_send_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(state == S_TX));
endmodule

// File: tb/kbd_host_port_tb.sv
module kbd_host_port_tb;
  localparam int INH = 40;
  localparam int TO  = 300;
  localparam int H   = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_sel = 1'b0, cpu_we = 1'b0, cpu_addr = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic irq, ps2_clk_oe, ps2_dat_oe;
  logic dev_clk = 1'b1, dev_dat = 1'b1;
  logic ps2_clk_i, ps2_dat_i;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  assign ps2_clk_i = dev_clk & ~ps2_clk_oe;
  assign ps2_dat_i = dev_dat & ~ps2_dat_oe;

  kbd_host_port #(.INHIBIT_CYC(INH), .TIMEOUT_CYC(TO)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .irq(irq), .ps2_clk_i(ps2_clk_i), .ps2_dat_i(ps2_dat_i),
    .ps2_clk_oe(ps2_clk_oe), .ps2_dat_oe(ps2_dat_oe));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cpu_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    cpu_sel = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_sel = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic cpu_read(input logic a, output logic [7:0] d);
    @(negedge clk);
    cpu_sel = 1'b1; cpu_we = 1'b0; cpu_addr = a;
    #1 d = cpu_rdata;
    @(negedge clk);
    cpu_sel = 1'b0;
  endtask

  task automatic dev_bit(input logic b);
    dev_dat = b;
    wait_cyc(H);
    dev_clk = 1'b0;
    wait_cyc(H);
    dev_clk = 1'b1;
  endtask

  task automatic dev_send(input logic [7:0] b, input logic par_flip, input logic stop_v);
    dev_bit(1'b0);
    for (int i = 0; i < 8; i++) dev_bit(b[i]);
    dev_bit((~^b) ^ par_flip);
    dev_bit(stop_v);
    dev_dat = 1'b1;
    wait_cyc(8);
  endtask

  task automatic dev_take(input logic ack, output logic [9:0] got);
    while (ps2_clk_oe) @(negedge clk);
    wait_cyc(H);
    for (int i = 0; i < 10; i++) begin
      dev_clk = 1'b0;
      wait_cyc(H);
      dev_clk = 1'b1;
      got[i] = ps2_dat_i;
      wait_cyc(H);
    end
    dev_bit(ack);
    dev_dat = 1'b1;
    wait_cyc(8);
  endtask

  task automatic t_reset;
    logic [7:0] s;
    chk("R1 clk_oe", ps2_clk_oe, 0);
    chk("R1 dat_oe", ps2_dat_oe, 0);
    chk("R1 irq", irq, 0);
    cpu_read(1'b1, s);
    chk("R1 status", s, 8'h00);
  endtask

  task automatic t_receive;
    logic [7:0] s, d;
    dev_send(8'hA5, 1'b0, 1'b1);
    cpu_read(1'b1, s);
    chk("R2 full flag", s[0], 1);
    chk("R4 irq off while disabled", irq, 0);
    cpu_read(1'b0, d);
    chk("R2 data A5", d, 8'hA5);
    cpu_read(1'b1, s);
    chk("R8 full cleared by data read", s[0], 0);
  endtask

  task automatic t_irq;
    logic [7:0] s, d;
    cpu_write(1'b1, 8'h01);
    cpu_read(1'b1, s);
    chk("R4 enable readback", s[6], 1);
    dev_send(8'h3C, 1'b0, 1'b1);
    chk("R4 irq on receive", irq, 1);
    cpu_read(1'b0, d);
    chk("R2 data 3C", d, 8'h3C);
    #1 chk("R8 irq drops after data read", irq, 0);
  endtask

  task automatic t_errors;
    logic [7:0] s, d;
    dev_send(8'h55, 1'b1, 1'b1);
    cpu_read(1'b1, s);
    chk("R3 parity error flag", s[2], 1);
    chk("R3 parity error no full", s[0], 0);
    cpu_read(1'b0, d);
    chk("R3 data kept after parity error", d, 8'h3C);
    cpu_read(1'b1, s);
    chk("R8 status read clears error", s[2], 0);
    dev_send(8'h0F, 1'b0, 1'b0);
    cpu_read(1'b1, s);
    chk("R3 stop error flag", s[2], 1);
    chk("R3 stop error no full", s[0], 0);
    chk("R3 irq stays low", irq, 0);
  endtask

  task automatic t_send;
    logic [7:0] s;
    logic [9:0] got;
    int n;
    cpu_write(1'b0, 8'hED);
    n = 0;
    while (ps2_clk_oe) begin n++; @(negedge clk); end
    chk("R5 inhibit length", n, INH);
    chk("R5 start bit driven at release", ps2_dat_oe, 1);
    cpu_read(1'b1, s);
    chk("R6 pending shown", s[1], 1);
    dev_take(1'b0, got);
    chk("R5 data bits", got[7:0], 8'hED);
    chk("R5 odd parity", got[8], ~^8'hED);
    chk("R5 stop released", got[9], 1);
    chk("R4 irq on send done", irq, 1);
    cpu_read(1'b1, s);
    chk("R7 done flag", s[4], 1);
    chk("R6 pending cleared", s[1], 0);
    #1 chk("R8 irq drops after status read", irq, 0);
  endtask

  task automatic t_busy;
    logic [7:0] s;
    logic [9:0] got;
    cpu_write(1'b0, 8'hF4);
    wait_cyc(5);
    cpu_write(1'b0, 8'h11);
    cpu_read(1'b1, s);
    chk("R6 busy flag", s[3], 1);
    chk("R6 still pending", s[1], 1);
    dev_take(1'b0, got);
    chk("R6 refused write had no effect", got[7:0], 8'hF4);
    chk("R6 parity of kept byte", got[8], ~^8'hF4);
    cpu_read(1'b1, s);
    chk("R7 done after busy case", s[4], 1);
  endtask

  task automatic t_nack;
    logic [7:0] s;
    logic [9:0] got;
    cpu_write(1'b0, 8'h42);
    dev_take(1'b1, got);
    cpu_read(1'b1, s);
    chk("R7 no-ack flag", s[5], 1);
    chk("R7 no done on no-ack", s[4], 0);
    cpu_read(1'b1, s);
    chk("R8 no-ack cleared", s[5], 0);
  endtask

  task automatic t_timeout;
    logic [7:0] s, d;
    dev_bit(1'b0);
    for (int i = 0; i < 3; i++) dev_bit(1'b1);
    dev_dat = 1'b1;
    wait_cyc(TO + 50);
    dev_send(8'h81, 1'b0, 1'b1);
    cpu_read(1'b1, s);
    chk("R9 no error after stall", s[2], 0);
    chk("R9 full after stall", s[0], 1);
    cpu_read(1'b0, d);
    chk("R9 clean byte after stall", d, 8'h81);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(4);
    t_reset();
    t_receive();
    t_irq();
    t_errors();
    t_send();
    t_busy();
    t_nack();
    t_timeout();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule